// File: doc/BRIEF.md
# Noise-Profile LLR Scaler

This block turns a signed channel metric into an 8-bit log-likelihood ratio by dividing it by a noise-plus-interference variance. The variance is not estimated. A 2-bit profile select picks one of four fixed schedules. Each schedule gives one variance for the first decoding iteration, one for iterations two to four, and one for iteration five and later. Every variance is a power of two, so the division is an arithmetic right shift and no divider is needed.

The iterative decoder feeds the block one metric per valid cycle. With each metric it supplies the current iteration index (counted from 1) and the profile select. The profile can be combined with any spacing setting of the surrounding decoder. The result comes out one clock later with its own valid strobe. It is clamped to the signed 8-bit range.

Top module: `llr_noise_scaler`

## Requirements
- R1: While reset is asserted and on the first cycle after it, out_valid is 0 and out_llr is 0.
- R2: out_valid equals in_valid of the previous clock cycle. The result for a metric accepted on edge k appears after edge k.
- R3: Profile select 2'b00 uses variance 1 in every iteration band (shift 0).
- R4: Profile select 2'b01 uses variances 8, 4, 1 for the first, early and late bands (shifts 3, 2, 0).
- R5: Profile select 2'b10 uses variances 4, 2, 1 (shifts 2, 1, 0).
- R6: Profile select 2'b11 uses variances 16, 4, 1 (shifts 4, 2, 0).
- R7: Iteration index 1 selects the first band, indices 2 to 4 select the early band, and 5 or more selects the late band. Index 0 is treated as 1.
- R8: The shift is arithmetic and rounds toward minus infinity. For example, -1 shifted by 2 gives -1, and -17 shifted by 4 gives -2. The sign of the result always matches the sign of the metric.
- R9: After shifting, a value above 127 gives 127 and a value below -128 gives -128.
- R10: When in_valid is 0, out_llr keeps its previous value, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Metric strobe |
| in_metric | input | 12 | Signed channel metric |
| in_iter | input | 5 | Iteration index, 1-based |
| in_profile | input | 2 | Noise profile select |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_llr | output | 8 | Saturated signed LLR |

## Verification
Each of the four profiles is driven in all three iteration bands. A metric that divides exactly shows a wrong shift amount. A small negative metric separates an arithmetic shift from a logical one, and floor rounding from truncation. The band edges are tried at indices 0, 1, 2, 4, 5 and a large index, so an off-by-one in the band decode shows up. Metrics around ±128 after shifting, including the most negative input, check the clamp. A held-input sequence with changing idle inputs checks that the output is held and that the valid strobe follows the input strobe.

// File: rtl/llr_scale_pkg.sv
package llr_scale_pkg;

    // iteration band selected by the 1-based iteration index
    typedef enum logic [1:0] {
        BAND_FIRST = 2'd0,
        BAND_EARLY = 2'd1,
        BAND_LATE  = 2'd2
    } band_t;

    // last index belonging to each band
    localparam int FIRST_LAST_ITER = 1;
    localparam int EARLY_LAST_ITER = 4;

    // width of the shift amount (largest shift is 4)
    localparam int SHIFT_W = 3;

    // profile codes
    localparam logic [1:0] PROF_FLAT   = 2'b00;
    localparam logic [1:0] PROF_STEEP  = 2'b01;
    localparam logic [1:0] PROF_MILD   = 2'b10;
    localparam logic [1:0] PROF_STRONG = 2'b11;

endpackage

// File: rtl/llr_iter_band.sv
module llr_iter_band
    import llr_scale_pkg::*;
#(
    parameter int ITER_W = 5
) (
    input  logic [ITER_W-1:0] iter_i,
    output band_t             band_o
);
    localparam logic [ITER_W-1:0] FIRST_LIM = ITER_W'(FIRST_LAST_ITER);
    localparam logic [ITER_W-1:0] EARLY_LIM = ITER_W'(EARLY_LAST_ITER);

    // index 0 falls into the first band with index 1
    always_comb begin
        if (iter_i <= FIRST_LIM) begin
            band_o = BAND_FIRST;
        end else if (iter_i <= EARLY_LIM) begin
            band_o = BAND_EARLY;
        end else begin
            band_o = BAND_LATE;
        end
    end
endmodule

// File: rtl/llr_shift_select.sv
module llr_shift_select
    import llr_scale_pkg::*;
(
    input  logic [1:0]         profile_i,
    input  band_t              band_i,
    output logic [SHIFT_W-1:0] shamt_o
);
    // log2 of variance per profile and band
    always_comb begin
        shamt_o = '0;
        unique case (profile_i)
            PROF_FLAT: shamt_o = '0;
            PROF_STEEP: begin
                case (band_i)
                    BAND_FIRST: shamt_o = SHIFT_W'(3);
                    BAND_EARLY: shamt_o = SHIFT_W'(2);
                    default:    shamt_o = '0;
                endcase
            end
            PROF_MILD: begin
                case (band_i)
                    BAND_FIRST: shamt_o = SHIFT_W'(2);
                    BAND_EARLY: shamt_o = SHIFT_W'(1);
                    default:    shamt_o = '0;
                endcase
            end
            PROF_STRONG: begin
                case (band_i)
                    BAND_FIRST: shamt_o = SHIFT_W'(4);
                    BAND_EARLY: shamt_o = SHIFT_W'(2);
                    default:    shamt_o = '0;
                endcase
            end
            default: shamt_o = '0;
        endcase
    end
endmodule

// File: rtl/llr_shift_sat.sv
module llr_shift_sat
    import llr_scale_pkg::*;
#(
    parameter int IN_W  = 12,
    parameter int OUT_W = 8
) (
    input  logic signed [IN_W-1:0]  metric_i,
    input  logic [SHIFT_W-1:0]      shamt_i,
    output logic signed [OUT_W-1:0] llr_o
);
    logic signed [IN_W-1:0] shifted;

    // sign-preserving division by 2**shamt, floor rounding
    always_comb begin
        shifted = metric_i >>> shamt_i;
    end

    generate
        if (IN_W > OUT_W) begin : g_clamp
            localparam logic signed [IN_W-1:0] MAXV =
                {{(IN_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
            localparam logic signed [IN_W-1:0] MINV = ~MAXV;
            always_comb begin
                if (shifted > MAXV) begin
                    llr_o = MAXV[OUT_W-1:0];
                end else if (shifted < MINV) begin
                    llr_o = MINV[OUT_W-1:0];
                end else begin
                    llr_o = shifted[OUT_W-1:0];
                end
            end
        end else begin : g_extend
            always_comb begin
                llr_o = OUT_W'(shifted);
            end
        end
    endgenerate
endmodule

// File: rtl/llr_noise_scaler.sv
module llr_noise_scaler
    import llr_scale_pkg::*;
#(
    parameter int METRIC_W = 12,
    parameter int ITER_W   = 5,
    parameter int LLR_W    = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    input  logic signed [METRIC_W-1:0] in_metric,
    input  logic [ITER_W-1:0]          in_iter,
    input  logic [1:0]                 in_profile,
    output logic                       out_valid,
    output logic signed [LLR_W-1:0]    out_llr
);
    localparam int LLR_MAX = (1 << (LLR_W - 1)) - 1;

    typedef struct packed {
        logic                    vld;
        logic signed [LLR_W-1:0] llr;
    } state_t;

    state_t             state_d, state_q;
    band_t              band;
    logic [SHIFT_W-1:0] shamt;
    logic signed [LLR_W-1:0] llr_new;

    llr_iter_band #(.ITER_W(ITER_W)) u_band (
        .iter_i (in_iter),
        .band_o (band)
    );

    llr_shift_select u_sel (
        .profile_i (in_profile),
        .band_i    (band),
        .shamt_o   (shamt)
    );

    llr_shift_sat #(.IN_W(METRIC_W), .OUT_W(LLR_W)) u_sat (
        .metric_i (in_metric),
        .shamt_i  (shamt),
        .llr_o    (llr_new)
    );

    always_comb begin
        state_d     = state_q;
        state_d.vld = in_valid;
        if (in_valid) begin
            state_d.llr = llr_new;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign out_valid = state_q.vld;
    assign out_llr   = state_q.llr;

    // sign-extended output for comparisons against the metric
    logic signed [METRIC_W-1:0] llr_wide;
    assign llr_wide = {{(METRIC_W-LLR_W){out_llr[LLR_W-1]}}, out_llr};

    assert_valid_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_valid_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_llr));
    assert_neg_sign_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_metric[METRIC_W-1]) |=> out_llr[LLR_W-1]);
    assert_pos_sign_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_metric[METRIC_W-1]) |=> !out_llr[LLR_W-1]);
    assert_flat_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_profile == PROF_FLAT
         && in_metric <= METRIC_W'(LLR_MAX) && in_metric >= -METRIC_W'(LLR_MAX + 1))
        |=> llr_wide == $past(in_metric));
    assert_flat_clip_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_profile == PROF_FLAT && in_metric > METRIC_W'(LLR_MAX))
        |=> out_llr == LLR_W'(LLR_MAX));
endmodule

// File: tb/llr_noise_scaler_tb.sv
module llr_noise_scaler_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 23;

    // columns: profile, iteration, metric, expected, requirement number
    localparam int VP [NV] = '{0,0,0, 1,1,1, 2,2,2, 3,3,3, 3,1,1, 1,3, 0,2,3, 1,2,2};
    localparam int VI [NV] = '{1,7,3, 1,3,9, 1,2,5, 1,4,6, 0,4,5, 2,1, 1,1,1, 31,2,2};
    localparam int VM [NV] = '{100,-50,300, 800,200,-90, -400,77,-128, 2047,-512,13,
                               160,40,40, -1,-17, -2048,-2048,-2048, 1023,255,256};
    localparam int VE [NV] = '{100,-50,127, 100,50,-90, -100,38,-128, 127,-128,13,
                               10,10,40, -1,-2, -128,-128,-128, 127,127,127};
    // rows: R3 R3 R9, R4 R4 R4, R5 R5 R5, R6 R6 R6, R7 R7 R7, R8 R8, R9 R9 R6, R9 R5 R9
    localparam int VR [NV] = '{3,3,9, 4,4,4, 5,5,5, 6,6,6, 7,7,7, 8,8, 9,9,6, 9,5,9};

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic signed [11:0] in_metric = '0;
    logic [4:0]        in_iter = '0;
    logic [1:0]        in_profile = '0;
    logic              out_valid;
    logic signed [7:0] out_llr;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    llr_noise_scaler u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_metric(in_metric),
        .in_iter(in_iter), .in_profile(in_profile),
        .out_valid(out_valid), .out_llr(out_llr)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic drive(input int p, input int it, input int m);
        @(negedge clk);
        in_valid   = 1'b1;
        in_profile = 2'(p);
        in_iter    = 5'(it);
        in_metric  = 12'(m);
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R1 valid", int'(out_valid), 0);
        check(out_llr == 8'sd0, "R1 llr", int'(out_llr), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0 && out_llr == 8'sd0, "R1 after release", int'(out_llr), 0);

        // table walk, one vector per cycle, streaming
        for (int k = 0; k < NV; k++) begin
            drive(VP[k], VI[k], VM[k]);
            @(negedge clk);
            check(out_valid == 1'b1, $sformatf("R2 vec%0d", k), int'(out_valid), 1);
            check(int'(out_llr) == VE[k], $sformatf("R%0d vec%0d", VR[k], k),
                  int'(out_llr), VE[k]);
            in_valid = 1'b0;
        end

        // R2: valid drops one cycle after input strobe drops
        drive(2, 2, 64);
        @(negedge clk);
        check(int'(out_llr) == 32, "R5 directed", int'(out_llr), 32);
        in_valid = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R2 drop", int'(out_valid), 0);

        // R10: idle inputs change, output held
        in_metric  = 12'sd2000;
        in_profile = 2'b00;
        in_iter    = 5'd9;
        @(negedge clk);
        check(int'(out_llr) == 32, "R10 hold a", int'(out_llr), 32);
        in_metric = -12'sd2000;
        @(negedge clk);
        check(int'(out_llr) == 32 && !out_valid, "R10 hold b", int'(out_llr), 32);

        // R7: index 0 versus 1 versus 2 with the strong profile
        drive(3, 0, -64);
        @(negedge clk);
        check(int'(out_llr) == -4, "R7 index0", int'(out_llr), -4);
        drive(3, 2, -64);
        @(negedge clk);
        check(int'(out_llr) == -16, "R7 index2", int'(out_llr), -16);
        in_valid = 1'b0;

        // R1: reset again mid-run clears state
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0 && out_llr == 8'sd0, "R1 re-reset", int'(out_llr), 0);
        rst_n = 1'b1;
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 5000 && !done; c++) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule